// File: doc/BRIEF.md
# Grayscale PWM Period Sequencer

This block turns a set of grayscale codes into on/off drive signals, one per channel. A reference-clock enable marks each grayscale clock. A display period lasts 2^GS_W of these clocks, numbered 1 to 2^GS_W. In each period a channel is driven on for the first N clocks, where N is its grayscale code. With the default GS_W of 16, a period lasts 65536 clocks.

A blank input forces every output dark and holds the period counter at its start. When blank is released, one period begins. Two settings then decide what happens next. With the repeat setting on, periods run back to back for as long as blank stays low. With it off, the block runs a single period and then stays dark until blank is raised and lowered again. When the timing-reset mode is on, a latch pulse restarts a fresh period at clock 1. This works even after a single-shot period has already finished. Grayscale codes are captured when each period starts, so new codes take effect at the next period boundary.

Top module: `gs_pwm_sequencer`

## Requirements
- R1: While rst_n is low, period_active is 0 and every pwm_out bit is 0. Reset leaves the block in the same state as a blank, so the first cycle with rst_n high and blank low starts a period.
- R2: When blank is sampled 1 at a clock edge, period_active and all pwm_out bits are 0 after that edge, and the period counter returns to clock 1.
- R3: A period has 2^GS_W grayscale clocks, numbered 1 to 2^GS_W. Channel i (gs_data bits [i*GS_W +: GS_W]) is on during clock k exactly when 1 <= k <= its code. A code of 0 never turns the channel on. The all-ones code keeps it on for every clock except the last.
- R4: With repeat_en at 1 when the last clock of a period ends, clock 1 of the next period follows on the next edge and period_active stays 1.
- R5: With repeat_en at 0, period_active falls and all outputs go off after the last clock ends. They stay off until blank is sampled 1 and then 0 again.
- R6: With tmreset_en at 1 and blank at 0, a latch_pulse sampled at an edge starts a new period at clock 1 on that edge. This holds whether a period was running or the block was idle. With tmreset_en at 0, latch_pulse has no effect on the outputs.
- R7: Grayscale codes are captured at the edge that starts a period. A change to gs_data in the middle of a period has no effect on pwm_out until the next period starts.
- R8: After blank is sampled 0 following a blank (or reset), period_active rises on that edge and the period begins at clock 1.
- R9: The period counter advances one clock only on edges where gsclk_en is 1. On other edges the counter and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gsclk_en | input | 1 | One grayscale reference clock per cycle where high |
| blank | input | 1 | Forces outputs off and holds the counter at its start |
| repeat_en | input | 1 | 1: periods run back to back; 0: single period |
| tmreset_en | input | 1 | Lets latch_pulse restart the period |
| latch_pulse | input | 1 | Single-cycle pulse from the data latch |
| gs_data | input | NUM_CH*GS_W | Grayscale codes, channel i at bits [i*GS_W +: GS_W] |
| pwm_out | output | NUM_CH | Per-channel on/off drive |
| period_active | output | 1 | High while a display period runs |

## Verification
The checker watches the cycle-level control rules on every cycle. It confirms that blank darkens all outputs and clears the counter, that the counter steps by one only on enabled clocks and holds otherwise, that the last clock either wraps or stops depending on repeat_en, and that a latch pulse in timing-reset mode returns the counter to clock 1. Some behaviour only shows up across a whole sequence, so the bench scenarios cover it. These scenarios cover:
- the exact on-time of each channel for the codes 0, 1, a mid value and all-ones;
- single-shot darkness that lasts until a fresh blank cycle;
- grayscale changes made mid-period that appear only at the next period;
- latch pulses that are ignored while timing reset is off.

// File: rtl/gs_pwm_pkg.sv
// Package for the grayscale PWM period sequencer.
// It holds the event type that the period controller decodes once per cycle.
package gs_pwm_pkg;

    // One action per clock edge, listed here in priority order.
    typedef enum logic [2:0] {
        EV_HOLD    = 3'd0,  // no change
        EV_BLANK   = 3'd1,  // blank forces idle and re-arms
        EV_RESTART = 3'd2,  // latch pulse in timing-reset mode
        EV_START   = 3'd3,  // first period after blank release
        EV_STEP    = 3'd4,  // advance one grayscale clock
        EV_WRAP    = 3'd5,  // last clock done, repeat on
        EV_STOP    = 3'd6   // last clock done, repeat off
    } seq_evt_e;

endpackage

// File: rtl/gs_period_ctrl.sv
// Period controller.
// It keeps the period counter (phase = clock number - 1), the running flag
// and the armed flag. The armed flag records that a blank has been seen since
// the last period start. Assumes gsclk_en is one system-clock wide per
// grayscale clock.
module gs_period_ctrl
    import gs_pwm_pkg::*;
#(
    parameter int GS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gsclk_en,
    input  logic            blank,
    input  logic            repeat_en,
    input  logic            tmreset_en,
    input  logic            latch_pulse,
    output logic            active,
    output logic [GS_W-1:0] phase,
    output logic            load_gs
);

    localparam logic [GS_W-1:0] PH_LAST = '1;

    seq_evt_e evt;
    logic     armed;

    // Pick this cycle's action by priority.
    always_comb begin
        if (blank)                              evt = EV_BLANK;
        else if (tmreset_en && latch_pulse)     evt = EV_RESTART;
        else if (!active && armed)              evt = EV_START;
        else if (active && gsclk_en) begin
            if (phase != PH_LAST)               evt = EV_STEP;
            else if (repeat_en)                 evt = EV_WRAP;
            else                                evt = EV_STOP;
        end
        else                                    evt = EV_HOLD;
    end

    // Capture grayscale codes whenever a period starts.
    assign load_gs = (evt == EV_RESTART) || (evt == EV_START) || (evt == EV_WRAP);

    // Update the counter and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            armed  <= 1'b1;
            phase  <= '0;
        end else begin
            unique case (evt)
                EV_BLANK: begin
                    active <= 1'b0;
                    armed  <= 1'b1;
                    phase  <= '0;
                end
                EV_RESTART, EV_START: begin
                    active <= 1'b1;
                    armed  <= 1'b0;
                    phase  <= '0;
                end
                EV_STEP:  phase <= phase + 1'b1;
                EV_WRAP:  phase <= '0;
                EV_STOP: begin
                    active <= 1'b0;
                    phase  <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gs_chan_cmp.sv
// Per-channel grayscale comparator.
// It holds a shadow copy of the channel code, loaded at each period start.
// The output is on while the period runs and phase < code, which means
// clock number <= code. Assumes phase counts from 0.
module gs_chan_cmp #(
    parameter int GS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [GS_W-1:0] gs_in,
    input  logic            active,
    input  logic [GS_W-1:0] phase,
    output logic            on
);

    logic [GS_W-1:0] shadow;

    // Hold the code steady for the whole period.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= gs_in;
    end

    // Drive on for clocks 1..code of a running period.
    assign on = active && (phase < shadow);

endmodule

// File: rtl/gs_pwm_sequencer.sv
// Top of the grayscale PWM period sequencer.
// One period controller feeds NUM_CH channel comparators. Assumes gs_data is
// packed with channel i at [i*GS_W +: GS_W].
module gs_pwm_sequencer #(
    parameter int NUM_CH = 4,
    parameter int GS_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   gsclk_en,
    input  logic                   blank,
    input  logic                   repeat_en,
    input  logic                   tmreset_en,
    input  logic                   latch_pulse,
    input  logic [NUM_CH*GS_W-1:0] gs_data,
    output logic [NUM_CH-1:0]      pwm_out,
    output logic                   period_active
);

    logic [GS_W-1:0] phase_q;
    logic            load_gs;

    gs_period_ctrl #(.GS_W(GS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gsclk_en    (gsclk_en),
        .blank       (blank),
        .repeat_en   (repeat_en),
        .tmreset_en  (tmreset_en),
        .latch_pulse (latch_pulse),
        .active      (period_active),
        .phase       (phase_q),
        .load_gs     (load_gs)
    );

    // Create one comparator for each channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gs_chan_cmp #(.GS_W(GS_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load_gs),
            .gs_in  (gs_data[ch*GS_W +: GS_W]),
            .active (period_active),
            .phase  (phase_q),
            .on     (pwm_out[ch])
        );
    end

endmodule

// File: rtl/gs_pwm_sequencer_chk.sv
// Assertion checker for gs_pwm_sequencer. It is bound to the top module and
// sees its ports plus the internal period counter.
module gs_pwm_sequencer_chk #(
    parameter int NUM_CH = 4,
    parameter int GS_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gsclk_en,
    input logic              blank,
    input logic              repeat_en,
    input logic              tmreset_en,
    input logic              latch_pulse,
    input logic [NUM_CH-1:0] pwm_out,
    input logic              period_active,
    input logic [GS_W-1:0]   phase_q
);

    localparam logic [GS_W-1:0] PH_LAST = '1;

    logic quiet;
    assign quiet = !blank && !(tmreset_en && latch_pulse);

    p_blank_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (!period_active && pwm_out == '0 && phase_q == '0));

    p_idle_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_active |-> pwm_out == '0);

    p_wrap_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && period_active && gsclk_en && phase_q == PH_LAST && repeat_en)
        |=> (period_active && phase_q == '0));

    p_single_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && period_active && gsclk_en && phase_q == PH_LAST && !repeat_en)
        |=> !period_active);

    p_latch_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && tmreset_en && latch_pulse) |=> (period_active && phase_q == '0));

    p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && period_active && gsclk_en && phase_q != PH_LAST)
        |=> (period_active && phase_q == $past(phase_q) + 1'b1));

    p_hold_idle_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && period_active && !gsclk_en)
        |=> (period_active && $stable(phase_q)));

endmodule

bind gs_pwm_sequencer gs_pwm_sequencer_chk #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gsclk_en      (gsclk_en),
    .blank         (blank),
    .repeat_en     (repeat_en),
    .tmreset_en    (tmreset_en),
    .latch_pulse   (latch_pulse),
    .pwm_out       (pwm_out),
    .period_active (period_active),
    .phase_q       (phase_q)
);

// File: tb/sim_gs_pwm_sequencer.sv
module sim_gs_pwm_sequencer;

    localparam int NUM_CH = 4;
    localparam int GS_W   = 8;
    localparam int PLEN   = 1 << GS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gsclk_en = 1'b0, blank = 1'b0, repeat_en = 1'b0;
    logic tmreset_en = 1'b0, latch_pulse = 1'b0;
    logic [NUM_CH*GS_W-1:0] gs_drv = '0;
    logic [NUM_CH-1:0] pwm_out;
    logic period_active;

    always #2.5 clk = ~clk;

    gs_pwm_sequencer #(.NUM_CH(NUM_CH), .GS_W(GS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .gsclk_en(gsclk_en), .blank(blank),
        .repeat_en(repeat_en), .tmreset_en(tmreset_en), .latch_pulse(latch_pulse),
        .gs_data(gs_drv), .pwm_out(pwm_out), .period_active(period_active)
    );

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Reference model, stated in terms of clock numbers 1..PLEN
    bit m_active = 1'b0;
    bit m_armed  = 1'b1;
    int m_clk    = 1;
    int m_gs [NUM_CH];

    function automatic logic [NUM_CH-1:0] exp_out();
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++)
            v[i] = m_active && (m_clk >= 1) && (m_clk <= m_gs[i]);
        return v;
    endfunction

    task automatic compare();
        logic [NUM_CH-1:0] e;
        e = exp_out();
        n_checks++;
        if (pwm_out !== e || period_active !== m_active) begin
            n_fails++;
            $display("FAIL %s: pwm_out=%b active=%b expected pwm_out=%b active=%b",
                     cur_req, pwm_out, period_active, e, m_active);
        end
    endtask

    task automatic capture_gs();
        for (int i = 0; i < NUM_CH; i++) m_gs[i] = int'(gs_drv[i*GS_W +: GS_W]);
    endtask

    function automatic void model_step();
        if (blank) begin
            m_active = 1'b0; m_armed = 1'b1; m_clk = 1;
        end else if (tmreset_en && latch_pulse) begin
            m_active = 1'b1; m_armed = 1'b0; m_clk = 1;
            for (int i = 0; i < NUM_CH; i++) m_gs[i] = int'(gs_drv[i*GS_W +: GS_W]);
        end else if (!m_active && m_armed) begin
            m_active = 1'b1; m_armed = 1'b0; m_clk = 1;
            for (int i = 0; i < NUM_CH; i++) m_gs[i] = int'(gs_drv[i*GS_W +: GS_W]);
        end else if (m_active && gsclk_en) begin
            if (m_clk < PLEN) m_clk++;
            else if (repeat_en) begin
                m_clk = 1;
                for (int i = 0; i < NUM_CH; i++) m_gs[i] = int'(gs_drv[i*GS_W +: GS_W]);
            end else begin
                m_active = 1'b0; m_clk = 1;
            end
        end
    endfunction

    // One cycle: check the outputs, drive the inputs, update the model.
    task automatic step(input logic tk, input logic bl, input logic rp,
                        input logic tr, input logic lp);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        gsclk_en = tk; blank = bl; repeat_en = rp; tmreset_en = tr; latch_pulse = lp;
        model_step();
    endtask

    task automatic run(input int n, input logic rp, input logic tr);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, rp, tr, 1'b0);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", wd);
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < NUM_CH; i++) m_gs[i] = 0;

        // R1: reset state
        cur_req = "R1";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            compare();
        end

        // R8: period begins right after reset/blank release; codes 0, max, 1, mid
        gs_drv = {8'd128, 8'd1, 8'd255, 8'd0};
        cur_req = "R8";
        run(4, 1'b1, 1'b0);
        // R3: on-time per code over a full period
        cur_req = "R3";
        run(PLEN, 1'b1, 1'b0);
        // R4: back-to-back repeat
        cur_req = "R4";
        run(PLEN + 20, 1'b1, 1'b0);

        // R9: sparse reference clock
        cur_req = "R9";
        for (int k = 0; k < 700; k++) step(1'($urandom % 2), 1'b0, 1'b1, 1'b0, 1'b0);

        // R7: mid-period code change is deferred
        cur_req = "R7";
        for (int k = 0; k < 3; k++) begin
            gs_drv = {$urandom, $urandom} [NUM_CH*GS_W-1:0];
            run(100, 1'b1, 1'b0);
        end
        run(PLEN, 1'b1, 1'b0);

        // R2: blank in the middle of a period
        cur_req = "R2";
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        cur_req = "R8";
        run(30, 1'b1, 1'b0);

        // R5: single shot, then stays dark until a new blank cycle
        cur_req = "R5";
        gs_drv = {8'd255, 8'd200, 8'd3, 8'd77};
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run(PLEN + 200, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        run(60, 1'b0, 1'b0);

        // R6: latch ignored with timing reset off, restarts with it on
        cur_req = "R6";
        run(PLEN, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
            run(10, 1'b0, 1'b0);
        end
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run(50, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run(PLEN + 30, 1'b0, 1'b1);

        // Random mix of every control
        cur_req = "R3";
        begin
            logic rp = 1'b1, tr = 1'b0;
            for (int k = 0; k < 20000; k++) begin
                if (k % 500 == 0) begin
                    rp = 1'($urandom % 2);
                    tr = 1'($urandom % 2);
                end
                if ($urandom % 200 == 0) gs_drv = {$urandom, $urandom} [NUM_CH*GS_W-1:0];
                step(1'($urandom % 4 != 0), 1'($urandom % 256 == 0), rp, tr,
                     1'($urandom % 300 == 0));
            end
        end
        @(negedge clk);
        compare();
        finish_up();
    end

endmodule